// File: doc/BRIEF.md
# Register Access Retry Sequencer

This block lets host logic read and write the registers of a peripheral that sits on a byte-oriented two-wire bus. The peripheral may refuse a transfer with a NAK while it is busy. A request names a register, a direction and a byte count. It also carries a flag that selects a slow-retry write, which is meant for the command that aborts or readies the peripheral. The sequencer turns the request into one or two bus transactions for a simple bus-master port. It counts retries and inserts the timed pauses between attempts, then reports completion with an error flag.

A write goes out as a single transaction: the register byte first, then the payload bytes in order. A read takes two phases. The first is a one-byte transaction that carries only the register number. After a pause comes a separate read transaction of the requested length. Each phase has its own bounded retry budget. The bus-master port contract is that a refusal is reported before any data byte moves, so a refused attempt leaves the payload stream untouched. Pause lengths are given in microseconds and converted to clock cycles from a clock-frequency parameter (rounded up). `N_S` is the short pause (60 us) and `N_L` is the long pause (210 us).

Top module: `regbus_retry_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `bm_cmd_valid` is 0 and `done` is 0.
- R2: A read (`req_write`=0) first issues a transaction with `bm_cmd_rnw`=0 and `bm_cmd_len`=1 whose only byte is the register number. After that transaction is acknowledged, it issues a transaction with `bm_cmd_rnw`=1 and `bm_cmd_len` equal to the requested length.
- R3: The register-number phase of a read makes at most 3 attempts. Exactly `N_S` idle cycles follow every refused attempt, including the last; the first attempt starts the cycle after acceptance. After the third refusal, `done` rises with `done_err`=1 once the `N_S` idle cycles have passed.
- R4: Every attempt of the data phase of a read is preceded by exactly `N_S` idle cycles after the previous response, and the phase makes at most 3 attempts. After the third refusal, `done` rises with `done_err`=1 in the very next cycle.
- R5: A write issues one transaction with `bm_cmd_rnw`=0 and `bm_cmd_len` = payload length + 1. Its bytes are the register number and then the payload in stream order. `done` rises with `done_err`=0 in the cycle after the acknowledge response.
- R6: A normal write (`req_long`=0) makes at most 3 attempts, with exactly `N_S` idle cycles after each refusal. A refused attempt takes no payload byte from the `wr_` stream. After the third refusal, `done` rises with `done_err`=1 once `N_S` idle cycles have passed.
- R7: A long write (`req_long`=1) makes at most 50 attempts, with exactly `N_L` idle cycles after each refusal. `req_long` has no effect on reads, which always use `N_S`.
- R8: `bm_cmd_dev` carries `cfg_dev_addr` (sampled at acceptance) when that value is nonzero, and 7'h20 when it is zero.
- R9: A request with length 0 or greater than 1260 causes no bus command. `done` rises with `done_err`=1 in the cycle after acceptance.
- R10: `done` is high for exactly one cycle. `req_ready` is 0 from the cycle after acceptance through the `done` cycle, and a `req_valid` raised in that window is not accepted.
- R11: Read data leaves on `rd_data`/`rd_valid` in bus order, with the first received byte first. `rd_ready` is passed to `bm_rx_ready`, so the bus is held back while the consumer stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dev_addr | input | 7 | Configured peripheral address, 0 selects the default 0x20 |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_long | input | 1 | Slow-retry mode for writes |
| req_reg | input | 8 | Register number |
| req_len | input | LEN_W | Payload or read byte count |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | Payload byte valid |
| wr_ready | output | 1 | Payload byte taken |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Consumer ready for read byte |
| done | output | 1 | One-cycle completion strobe |
| done_err | output | 1 | Completion carries an error |
| bm_cmd_valid | output | 1 | Bus transaction request |
| bm_cmd_ready | input | 1 | Bus master accepts transaction |
| bm_cmd_dev | output | 7 | Peripheral address of the transaction |
| bm_cmd_rnw | output | 1 | 1 = bus read, 0 = bus write |
| bm_cmd_len | output | LEN_W | Byte count of the transaction |
| bm_tx_data | output | 8 | Byte to transmit |
| bm_tx_valid | output | 1 | Transmit byte valid |
| bm_tx_ready | input | 1 | Bus master takes transmit byte |
| bm_rx_data | input | 8 | Received byte |
| bm_rx_valid | input | 1 | Received byte valid |
| bm_rx_ready | output | 1 | Sequencer takes received byte |
| bm_resp_valid | input | 1 | Transaction finished |
| bm_resp_nak | input | 1 | Transaction was refused |

## Verification
A retry counter that is wrong shows up as one attempt too many or too few on `bm_cmd_valid`, plus a `done` that comes early or late. Both are visible within one pause after the last response. A pause timer that is off by even one cycle shifts the next `bm_cmd_valid` rise, so the bench measures every gap between a response and the following command. A wrong phase or byte count shows at once: the reported transaction length changes, the byte order changes, or payload is taken from the write stream during a refused attempt.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_XFER,
      ST_WAIT,
      ST_DONE
   } rbs_state_e;

   typedef enum logic [1:0] {
      PH_WRITE,
      PH_RADDR,
      PH_RDATA
   } rbs_phase_e;

   function automatic int us_to_cycles(input longint clk_hz, input int us);
      return int'((clk_hz * longint'(us) + 64'd999_999) / 64'd1_000_000);
   endfunction

endpackage

// File: rtl/rbs_wait_timer.sv
module rbs_wait_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign expired = (cnt_q == '0);

   // R3: a nonzero load keeps the pause running for the following cycle
   p_load_holds_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/rbs_try_counter.sv
module rbs_try_counter #(
   parameter int TRY_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             bump,
   input  logic [TRY_W-1:0] limit,
   output logic             last
);

   logic [TRY_W-1:0] used_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         used_q <= '0;
      end else if (clr) begin
         used_q <= '0;
      end else if (bump) begin
         used_q <= used_q + TRY_W'(1);
      end
   end

   assign last = ({1'b0, used_q} + (TRY_W+1)'(1)) >= {1'b0, limit};

   // R6: no refusal is ever counted beyond the attempt budget
   p_budget_kept_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      bump |-> (used_q < limit));

endmodule

// File: rtl/rbs_byte_path.sv
module rbs_byte_path #(
   parameter int DATA_W = 8,
   parameter int LEN_W  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              active,
   input  logic              rnw,
   input  logic [LEN_W-1:0]  cmd_len,
   input  logic [DATA_W-1:0] head_byte,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_valid,
   output logic              wr_ready,
   output logic [DATA_W-1:0] bm_tx_data,
   output logic              bm_tx_valid,
   input  logic              bm_tx_ready,
   input  logic [DATA_W-1:0] bm_rx_data,
   input  logic              bm_rx_valid,
   output logic              bm_rx_ready,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   input  logic              rd_ready
);

   logic [LEN_W-1:0] sent_q;
   logic             room;
   logic             at_head;
   logic             tx_go;

   assign room    = (sent_q < cmd_len);
   assign at_head = (sent_q == '0);

   always_comb begin
      bm_tx_valid = active && !rnw && room && (at_head || wr_valid);
      bm_tx_data  = at_head ? head_byte : wr_data;
      wr_ready    = active && !rnw && room && !at_head && bm_tx_ready;
      rd_valid    = active && rnw && bm_rx_valid;
      rd_data     = bm_rx_data;
      bm_rx_ready = active && rnw && rd_ready;
   end

   assign tx_go = bm_tx_valid && bm_tx_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sent_q <= '0;
      end else if (start) begin
         sent_q <= '0;
      end else if (tx_go) begin
         sent_q <= sent_q + LEN_W'(1);
      end
   end

   // R5: transmission stops once the announced byte count has gone out
   p_tx_stops_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (tx_go && sent_q == cmd_len - LEN_W'(1)) |=> !bm_tx_valid);

endmodule

// File: rtl/regbus_retry_seq.sv
module regbus_retry_seq
   import rbs_pkg::*;
#(
   parameter int          CLK_HZ      = 50_000_000,
   parameter int          SHORT_US    = 60,
   parameter int          LONG_US     = 210,
   parameter int          SHORT_TRIES = 3,
   parameter int          LONG_TRIES  = 50,
   parameter logic [6:0]  DEF_DEV     = 7'h20,
   parameter int          MAX_LEN     = 1260,
   parameter int          LEN_W       = $clog2(MAX_LEN + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [6:0]       cfg_dev_addr,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_write,
   input  logic             req_long,
   input  logic [7:0]       req_reg,
   input  logic [LEN_W-1:0] req_len,
   input  logic [7:0]       wr_data,
   input  logic             wr_valid,
   output logic             wr_ready,
   output logic [7:0]       rd_data,
   output logic             rd_valid,
   input  logic             rd_ready,
   output logic             done,
   output logic             done_err,
   output logic             bm_cmd_valid,
   input  logic             bm_cmd_ready,
   output logic [6:0]       bm_cmd_dev,
   output logic             bm_cmd_rnw,
   output logic [LEN_W-1:0] bm_cmd_len,
   output logic [7:0]       bm_tx_data,
   output logic             bm_tx_valid,
   input  logic             bm_tx_ready,
   input  logic [7:0]       bm_rx_data,
   input  logic             bm_rx_valid,
   output logic             bm_rx_ready,
   input  logic             bm_resp_valid,
   input  logic             bm_resp_nak
);

   localparam int WAIT_S   = us_to_cycles(longint'(CLK_HZ), SHORT_US);
   localparam int WAIT_L   = us_to_cycles(longint'(CLK_HZ), LONG_US);
   localparam int WAIT_MAX = (WAIT_L > WAIT_S) ? WAIT_L : WAIT_S;
   localparam int CNT_W    = $clog2(WAIT_MAX + 1);
   localparam int TRY_MAX  = (LONG_TRIES > SHORT_TRIES) ? LONG_TRIES : SHORT_TRIES;
   localparam int TRY_W    = $clog2(TRY_MAX + 1);

   initial begin : elab_checks
      assert (SHORT_TRIES >= 1 && LONG_TRIES >= 1) else $fatal(1, "attempt budgets must be positive");
      assert (WAIT_S >= 1 && WAIT_L >= 1) else $fatal(1, "pauses must last at least one cycle");
      assert (MAX_LEN + 1 < (1 << LEN_W)) else $fatal(1, "LEN_W too narrow for MAX_LEN + 1");
   end

   rbs_state_e       state_q;
   rbs_phase_e       phase_q;
   logic [6:0]       dev_q;
   logic [7:0]       reg_q;
   logic [LEN_W-1:0] len_q;
   logic             long_q;
   logic             final_q;
   logic             err_q;

   logic             accept;
   logic             len_bad;
   logic             resp_hit;
   logic             nak_hit;
   logic             ack_hit;
   logic             try_last;
   logic             try_clr;
   logic [TRY_W-1:0] try_limit;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_expired;
   logic             slow_mode;

   assign accept    = req_valid && req_ready;
   assign len_bad   = (req_len == '0) || (req_len > LEN_W'(MAX_LEN));
   assign resp_hit  = (state_q == ST_XFER) && bm_resp_valid;
   assign nak_hit   = resp_hit && bm_resp_nak;
   assign ack_hit   = resp_hit && !bm_resp_nak;
   assign slow_mode = (phase_q == PH_WRITE) && long_q;

   always_comb begin
      try_limit = slow_mode ? TRY_W'(LONG_TRIES) : TRY_W'(SHORT_TRIES);
      tmr_val   = slow_mode ? CNT_W'(WAIT_L - 1) : CNT_W'(WAIT_S - 1);
      tmr_load  = (ack_hit && phase_q == PH_RADDR)
               || (nak_hit && !(phase_q == PH_RDATA && try_last));
      try_clr   = accept || (ack_hit && phase_q == PH_RADDR);
      case (phase_q)
         PH_WRITE: bm_cmd_len = len_q + LEN_W'(1);
         PH_RADDR: bm_cmd_len = LEN_W'(1);
         default:  bm_cmd_len = len_q;
      endcase
   end

   rbs_try_counter #(.TRY_W(TRY_W)) u_tries (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (try_clr),
      .bump  (nak_hit),
      .limit (try_limit),
      .last  (try_last)
   );

   rbs_wait_timer #(.CNT_W(CNT_W)) u_pause (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         phase_q <= PH_WRITE;
         dev_q   <= DEF_DEV;
         reg_q   <= '0;
         len_q   <= '0;
         long_q  <= 1'b0;
         final_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  dev_q   <= (cfg_dev_addr != '0) ? cfg_dev_addr : DEF_DEV;
                  reg_q   <= req_reg;
                  len_q   <= req_len;
                  long_q  <= req_long;
                  final_q <= 1'b0;
                  phase_q <= req_write ? PH_WRITE : PH_RADDR;
                  err_q   <= len_bad;
                  state_q <= len_bad ? ST_DONE : ST_CMD;
               end
            end
            ST_CMD: begin
               if (bm_cmd_ready) state_q <= ST_XFER;
            end
            ST_XFER: begin
               if (ack_hit) begin
                  if (phase_q == PH_RADDR) begin
                     phase_q <= PH_RDATA;
                     state_q <= ST_WAIT;
                  end else begin
                     err_q   <= 1'b0;
                     state_q <= ST_DONE;
                  end
               end else if (nak_hit) begin
                  if (try_last && phase_q == PH_RDATA) begin
                     err_q   <= 1'b1;
                     state_q <= ST_DONE;
                  end else begin
                     final_q <= try_last;
                     err_q   <= try_last;
                     state_q <= ST_WAIT;
                  end
               end
            end
            ST_WAIT: begin
               if (tmr_expired) state_q <= final_q ? ST_DONE : ST_CMD;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready    = (state_q == ST_IDLE);
   assign done         = (state_q == ST_DONE);
   assign done_err     = err_q;
   assign bm_cmd_valid = (state_q == ST_CMD);
   assign bm_cmd_dev   = dev_q;
   assign bm_cmd_rnw   = (phase_q == PH_RDATA);

   rbs_byte_path #(.DATA_W(8), .LEN_W(LEN_W)) u_bytes (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (bm_cmd_valid && bm_cmd_ready),
      .active      (state_q == ST_XFER),
      .rnw         (bm_cmd_rnw),
      .cmd_len     (bm_cmd_len),
      .head_byte   (reg_q),
      .wr_data     (wr_data),
      .wr_valid    (wr_valid),
      .wr_ready    (wr_ready),
      .bm_tx_data  (bm_tx_data),
      .bm_tx_valid (bm_tx_valid),
      .bm_tx_ready (bm_tx_ready),
      .bm_rx_data  (bm_rx_data),
      .bm_rx_valid (bm_rx_valid),
      .bm_rx_ready (bm_rx_ready),
      .rd_data     (rd_data),
      .rd_valid    (rd_valid),
      .rd_ready    (rd_ready)
   );

   // R2: a pending transaction request holds steady until taken
   p_cmd_held_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (bm_cmd_valid && !bm_cmd_ready) |=> (bm_cmd_valid && $stable(bm_cmd_len) && $stable(bm_cmd_rnw)));

   // R10: completion strobe lasts one cycle
   p_done_pulse_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: an accepted request closes the request port
   p_busy_closed_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);

   // R9: an out-of-range length completes at once with an error
   p_bad_len_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (accept && len_bad) |=> (done && done_err && !bm_cmd_valid));

endmodule

// File: tb/regbus_retry_seq_tb_top.sv
module regbus_retry_seq_tb_top;

   localparam int CLK_HZ  = 1_000_000;
   localparam int MAX_LEN = 1260;
   localparam int LEN_W   = $clog2(MAX_LEN + 2);
   localparam int NS      = 60;
   localparam int NL      = 210;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [6:0]       cfg_dev_addr = '0;
   logic             req_valid = 1'b0, req_write = 1'b0, req_long = 1'b0;
   logic [7:0]       req_reg = '0;
   logic [LEN_W-1:0] req_len = '0;
   logic             req_ready;
   logic [7:0]       wr_data = '0;
   logic             wr_valid = 1'b0, wr_ready;
   logic [7:0]       rd_data;
   logic             rd_valid, rd_ready = 1'b0;
   logic             done, done_err;
   logic             bm_cmd_valid, bm_cmd_ready = 1'b0, bm_cmd_rnw;
   logic [6:0]       bm_cmd_dev;
   logic [LEN_W-1:0] bm_cmd_len;
   logic [7:0]       bm_tx_data;
   logic             bm_tx_valid, bm_tx_ready = 1'b0;
   logic [7:0]       bm_rx_data = '0;
   logic             bm_rx_valid = 1'b0, bm_rx_ready;
   logic             bm_resp_valid = 1'b0, bm_resp_nak = 1'b0;

   regbus_retry_seq #(.CLK_HZ(CLK_HZ), .MAX_LEN(MAX_LEN)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_dev_addr(cfg_dev_addr),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_long(req_long), .req_reg(req_reg), .req_len(req_len),
      .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
      .done(done), .done_err(done_err),
      .bm_cmd_valid(bm_cmd_valid), .bm_cmd_ready(bm_cmd_ready), .bm_cmd_dev(bm_cmd_dev),
      .bm_cmd_rnw(bm_cmd_rnw), .bm_cmd_len(bm_cmd_len),
      .bm_tx_data(bm_tx_data), .bm_tx_valid(bm_tx_valid), .bm_tx_ready(bm_tx_ready),
      .bm_rx_data(bm_rx_data), .bm_rx_valid(bm_rx_valid), .bm_rx_ready(bm_rx_ready),
      .bm_resp_valid(bm_resp_valid), .bm_resp_nak(bm_resp_nak)
   );

   int checks = 0, errors = 0, cyc = 0;
   int cmd_start_q[$], resp_q[$], cmd_len_q[$];
   logic [6:0] cmd_dev_q[$];
   bit cmd_rnw_q[$];
   logic [7:0] txq[$], rdq[$], wq[$];
   int nak_left = 0, rx_base = 0;
   int done_cyc = 0, done_cnt = 0, accept_cyc = 0;
   bit done_err_s = 1'b0, busy_m = 1'b0, finished = 1'b0;
   int rs = 0, rs_cnt = 0, rs_len = 0, rs_dly = 0;
   bit rs_nak = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // Cycle model: responder, streams and per-clock comparison of the request port
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         bm_cmd_ready  = (rs == 1);
         bm_resp_valid = (rs == 5);
         bm_resp_nak   = rs_nak;
         bm_tx_ready   = (rs == 3);
         bm_rx_valid   = (rs == 4);
         bm_rx_data    = 8'(rx_base + rs_cnt);
         wr_valid      = (wq.size() > 0);
         wr_data       = (wq.size() > 0) ? wq[0] : 8'h00;
         rd_ready      = (cyc % 3) != 0;
         #1;
         if (rst_n) begin
            if (req_ready !== !busy_m) chk(1'b0, "R10 req_ready vs model", int'(req_ready), int'(!busy_m));
            if (req_valid && req_ready) begin
               accept_cyc = cyc;
               busy_m = 1'b1;
            end
            if (done) begin
               done_cnt++;
               done_cyc = cyc;
               done_err_s = done_err;
               busy_m = 1'b0;
            end
            if (wr_valid && wr_ready) void'(wq.pop_front());
            if (rd_valid && rd_ready) rdq.push_back(rd_data);
            case (rs)
               0: if (bm_cmd_valid) begin
                     cmd_start_q.push_back(cyc);
                     rs = 1;
                  end
               1: begin
                     cmd_dev_q.push_back(bm_cmd_dev);
                     cmd_rnw_q.push_back(bm_cmd_rnw);
                     cmd_len_q.push_back(int'(bm_cmd_len));
                     rs_len = int'(bm_cmd_len);
                     rs_cnt = 0;
                     if (nak_left > 0) begin
                        nak_left--;
                        rs_nak = 1'b1;
                        rs_dly = 2;
                        rs = 2;
                     end else begin
                        rs_nak = 1'b0;
                        rs = bm_cmd_rnw ? 4 : 3;
                     end
                  end
               2: begin
                     rs_dly--;
                     if (rs_dly == 0) rs = 5;
                  end
               3: if (bm_tx_valid) begin
                     txq.push_back(bm_tx_data);
                     rs_cnt++;
                     if (rs_cnt == rs_len) rs = 5;
                  end
               4: if (bm_rx_ready) begin
                     rs_cnt++;
                     if (rs_cnt == rs_len) rs = 5;
                  end
               default: begin
                     resp_q.push_back(cyc);
                     rs = 0;
                  end
            endcase
         end
      end
   end

   task automatic clear_logs();
      cmd_start_q.delete(); resp_q.delete(); cmd_len_q.delete();
      cmd_dev_q.delete(); cmd_rnw_q.delete(); txq.delete(); rdq.delete();
   endtask

   task automatic run_req(input bit wr, input bit lng, input logic [7:0] rg,
                          input int len, input logic [6:0] cfg);
      int start;
      while (busy_m) @(negedge clk);
      start = done_cnt;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_long = lng;
      req_reg = rg; req_len = LEN_W'(len); cfg_dev_addr = cfg;
      @(negedge clk);
      req_valid = 1'b0;
      while (done_cnt == start) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic chk_timing(input string tag, input int ncmd, input int gap, input int done_gap);
      chk(cmd_start_q.size() == ncmd, {tag, " attempt count"}, cmd_start_q.size(), ncmd);
      if (cmd_start_q.size() == ncmd && resp_q.size() == ncmd && ncmd > 0) begin
         chk(cmd_start_q[0] - accept_cyc == 1, {tag, " first command delay"}, cmd_start_q[0] - accept_cyc, 1);
         for (int i = 1; i < ncmd; i++)
            chk(cmd_start_q[i] - resp_q[i-1] - 1 == gap, {tag, " pause cycles"}, cmd_start_q[i] - resp_q[i-1] - 1, gap);
         chk(done_cyc - resp_q[ncmd-1] - 1 == done_gap, {tag, " done delay"}, done_cyc - resp_q[ncmd-1] - 1, done_gap);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #2;
      chk(req_ready == 1'b1 && bm_cmd_valid == 1'b0 && done == 1'b0, "R1 outputs in reset", int'({req_ready, bm_cmd_valid, done}), 3'b100);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #2;
      chk(req_ready == 1'b1, "R1 req_ready after reset", int'(req_ready), 1);
      chk(bm_cmd_valid == 1'b0 && done == 1'b0, "R1 idle outputs", int'({bm_cmd_valid, done}), 0);

      // R5 R8: plain write, default device address
      clear_logs(); nak_left = 0; wq = '{8'h11, 8'h22, 8'h33};
      run_req(1'b1, 1'b0, 8'h05, 3, 7'h00);
      chk_timing("R5 write", 1, NS, 0);
      chk(cmd_len_q.size() == 1 && cmd_len_q[0] == 4, "R5 length plus one", cmd_len_q.size() > 0 ? cmd_len_q[0] : -1, 4);
      chk(txq.size() == 4 && txq[0] == 8'h05 && txq[1] == 8'h11 && txq[2] == 8'h22 && txq[3] == 8'h33,
          "R5 byte order", txq.size(), 4);
      chk(cmd_dev_q.size() == 1 && cmd_dev_q[0] == 7'h20, "R8 default device", cmd_dev_q.size() > 0 ? int'(cmd_dev_q[0]) : -1, 32);
      chk(done_err_s == 1'b0, "R5 no error", int'(done_err_s), 0);

      // R6: two refusals then success, payload untouched by refusals
      clear_logs(); nak_left = 2; wq = '{8'hA1, 8'hA2};
      run_req(1'b1, 1'b0, 8'h18, 2, 7'h00);
      chk_timing("R6 retried write", 3, NS, 0);
      chk(txq.size() == 3 && txq[1] == 8'hA1 && txq[2] == 8'hA2, "R6 payload after refusals", txq.size(), 3);
      chk(done_err_s == 1'b0, "R6 success flag", int'(done_err_s), 0);

      // R6: budget exhausted
      clear_logs(); nak_left = 3; wq = '{8'h5A};
      run_req(1'b1, 1'b0, 8'h01, 1, 7'h00);
      chk_timing("R6 exhausted write", 3, NS, NS);
      chk(done_err_s == 1'b1, "R6 error flag", int'(done_err_s), 1);
      chk(wq.size() == 1, "R6 payload left in stream", wq.size(), 1);
      wq.delete();

      // R7: long write, five refusals then success
      clear_logs(); nak_left = 5; wq = '{8'h40};
      run_req(1'b1, 1'b1, 8'h01, 1, 7'h00);
      chk_timing("R7 long write", 6, NL, 0);
      chk(done_err_s == 1'b0, "R7 long success", int'(done_err_s), 0);

      // R7: long write, budget of 50 exhausted
      clear_logs(); nak_left = 60; wq = '{8'h40};
      run_req(1'b1, 1'b1, 8'h01, 1, 7'h00);
      chk_timing("R7 long exhausted", 50, NL, NL);
      chk(done_err_s == 1'b1, "R7 long error", int'(done_err_s), 1);
      nak_left = 0; wq.delete();

      // R2 R11 R8: read of 4 bytes, configured device
      clear_logs(); rx_base = 8'hC0;
      run_req(1'b0, 1'b0, 8'h06, 4, 7'h35);
      chk_timing("R2 read", 2, NS, 0);
      chk(cmd_rnw_q.size() == 2 && cmd_rnw_q[0] == 1'b0 && cmd_len_q[0] == 1, "R2 address phase", cmd_len_q.size() > 0 ? cmd_len_q[0] : -1, 1);
      chk(txq.size() == 1 && txq[0] == 8'h06, "R2 register byte", txq.size() > 0 ? int'(txq[0]) : -1, 6);
      chk(cmd_rnw_q.size() == 2 && cmd_rnw_q[1] == 1'b1 && cmd_len_q[1] == 4, "R2 data phase", cmd_len_q.size() > 1 ? cmd_len_q[1] : -1, 4);
      chk(cmd_dev_q.size() == 2 && cmd_dev_q[0] == 7'h35 && cmd_dev_q[1] == 7'h35, "R8 configured device", cmd_dev_q.size() > 0 ? int'(cmd_dev_q[0]) : -1, 53);
      chk(rdq.size() == 4, "R11 byte count", rdq.size(), 4);
      for (int i = 0; i < 4 && i < rdq.size(); i++)
         chk(rdq[i] == 8'(8'hC0 + i), "R11 bus order", int'(rdq[i]), 8'hC0 + i);
      chk(done_err_s == 1'b0, "R2 read ok", int'(done_err_s), 0);

      // R3 R7: two refused address phases; long flag must not stretch pauses
      clear_logs(); nak_left = 2; rx_base = 8'h70;
      run_req(1'b0, 1'b1, 8'h0A, 2, 7'h00);
      chk_timing("R3 R7 read retry", 4, NS, 0);
      chk(cmd_rnw_q.size() == 4 && cmd_rnw_q[2] == 1'b0 && cmd_rnw_q[3] == 1'b1, "R3 phase sequence", cmd_rnw_q.size(), 4);
      chk(rdq.size() == 2 && rdq[0] == 8'h70 && rdq[1] == 8'h71, "R11 data after retry", rdq.size(), 2);

      // R3: address phase exhausted
      clear_logs(); nak_left = 3;
      run_req(1'b0, 1'b0, 8'h0B, 1, 7'h00);
      chk_timing("R3 address exhausted", 3, NS, NS);
      chk(done_err_s == 1'b1, "R3 error flag", int'(done_err_s), 1);

      // R4: address accepted, data phase refused three times
      clear_logs(); nak_left = 0;
      fork
         begin
            while (resp_q.size() == 0) @(negedge clk);
            nak_left = 3;
         end
         run_req(1'b0, 1'b0, 8'h0C, 2, 7'h00);
      join
      chk_timing("R4 data exhausted", 4, NS, 0);
      chk(done_err_s == 1'b1, "R4 error flag", int'(done_err_s), 1);
      chk(rdq.size() == 0, "R4 no data delivered", rdq.size(), 0);
      nak_left = 0;

      // R9: bad lengths
      clear_logs();
      run_req(1'b1, 1'b0, 8'h01, 0, 7'h00);
      chk(done_cyc - accept_cyc == 1 && done_err_s == 1'b1, "R9 zero length", done_cyc - accept_cyc, 1);
      run_req(1'b0, 1'b0, 8'h01, MAX_LEN + 1, 7'h00);
      chk(done_cyc - accept_cyc == 1 && done_err_s == 1'b1, "R9 oversize", done_cyc - accept_cyc, 1);
      chk(cmd_start_q.size() == 0, "R9 no bus command", cmd_start_q.size(), 0);

      // R10: request raised while busy is not taken
      clear_logs(); nak_left = 1; wq = '{8'h99};
      fork
         run_req(1'b1, 1'b0, 8'h02, 1, 7'h00);
         begin
            repeat (5) @(negedge clk);
            req_valid = 1'b1;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
         end
      join
      chk(cmd_start_q.size() == 2, "R10 busy request ignored", cmd_start_q.size(), 2);
      chk(done_err_s == 1'b0, "R10 first request completed", int'(done_err_s), 0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 150_000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule